// File: doc/BRIEF.md
# Daisy-Chained FIFO Depth-Expansion Ring

This block builds a deep first-in first-out buffer out of a ring of identical slices. Each slice has a small local memory, its own write and read pointers, and its own active-low full and empty flags. No central address decoder exists. The right to write and the right to read each move around the ring as a token. The slice that holds the write token takes incoming words. When it stores into its last location, it pulses the write lane of its expansion-out link. The next slice sees that pulse on its expansion-in link and takes the write token. The read token moves around the ring in the same way on a separate read lane.

After reset every slice clears its pointers to location zero. The slice whose first-load input is low holds both tokens. In the wrapper, only slice 0 has first-load low. The expansion-out of the last slice feeds the expansion-in of the first slice, which closes the ring. With a single slice, the link loops back onto itself and the slice behaves as a plain FIFO. The wrapper combines the local flags of all slices into composite flags. A composite flag goes low only when every slice drives its local flag low.

The read side is first-word-fall-through. The oldest word is always on `rd_data` while `empty_n` is high, and `rd_en` pops it.

Top module: `fifo_chain`

## Requirements
- R1: After reset every slice has both pointers at location zero and a local count of zero. `empty_n` is 0 and `full_n` is 1. Bit 0 of `wr_owner` and bit 0 of `rd_owner` are set and all other bits are clear, because only slice 0 has first-load low.
- R2: A write is accepted only by the slice whose bit is set in `wr_owner`, and only while its local full flag is high. The word is stored at that slice's write pointer, and the pointer then advances by one.
- R3: While `empty_n` is 1, `rd_data` shows the oldest stored word. It is taken from the slice whose bit is set in `rd_owner`. When `rd_en` is high, that word is popped at the clock edge.
- R4: A write into a slice's last location drives that slice's expansion-out write lane high for exactly one clock. At that edge the slice gives up the write token, and the next slice (bit k+1 of `wr_owner`) takes it.
- R5: A read from a slice's last location drives that slice's expansion-out read lane high for exactly one clock. At that edge the read token moves to the next slice in `rd_owner`.
- R6: The expansion-out of the last slice feeds the expansion-in of slice 0. After SLICE_DEPTH×N_SLICES accepted writes, or the same number of accepted reads, the matching token is back at bit 0.
- R7: `full_n` is 0 only when every slice's local full flag is low. `empty_n` is 0 only when every slice's local empty flag is low.
- R8: A write while `full_n` is 0 is ignored. The stored words, `rd_data` and `wr_owner` are unchanged, and a read in the same cycle is still performed.
- R9: A read while `empty_n` is 0 is ignored. `rd_owner` is unchanged, and a write in the same cycle is still stored.
- R10: The ring holds exactly SLICE_DEPTH×N_SLICES words. Words leave in the order they were written, across slice boundaries.
- R11: With N_SLICES = 1, the slice's expansion-out feeds its own expansion-in. Both owner bits stay set, and the block acts as a SLICE_DEPTH-deep FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read (pop) request |
| rd_data | output | DW | Oldest word (first-word-fall-through) |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |
| wr_owner | output | N_SLICES | Bit k set: slice k holds the write token |
| rd_owner | output | N_SLICES | Bit k set: slice k holds the read token |

## Verification
On every cycle the assertions check the following:
- Each token has exactly one owner.
- An expansion-out pulse lasts one clock, and the next slice owns the token at the following edge.
- A full slice stays full, and an empty slice stays empty, unless the opposite operation happens.
- An empty ring with no write stays empty.

Only the bench's scenarios can show the rest:
- Data order across slice boundaries and around the ring.
- The exact total capacity.
- That writes to a full ring and reads from an empty ring are ignored while the opposite operation still proceeds.
- That a one-slice ring loops its link back onto itself.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // Expansion link: separate lanes for write-token and read-token handoff
  typedef struct packed {
    logic wr;
    logic rd;
  } xlink_t;

  function automatic logic at_last(input int unsigned ptr, input int unsigned depth);
    return ptr == depth - 1;
  endfunction

  function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/chain_slice_mem.sv
module chain_slice_mem #(
  parameter int DW    = 9,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/chain_slice_ctl.sv
module chain_slice_ctl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fl_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  xlink_t        xi,
  output xlink_t        xo,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          wr_tok,
  output logic          rd_tok,
  output logic          ff_n,
  output logic          ef_n
);
  logic [CW-1:0] cnt;
  logic          wr_last, rd_last;

  assign ff_n   = (cnt != CW'(DEPTH));
  assign ef_n   = (cnt != '0);
  assign wr_acc = wr_en & wr_tok & ff_n;
  assign rd_acc = rd_en & rd_tok & ef_n;

  assign wr_last = wr_acc & at_last(32'(wptr), DEPTH);
  assign rd_last = rd_acc & at_last(32'(rptr), DEPTH);
  assign xo.wr   = wr_last;
  assign xo.rd   = rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_tok <= ~fl_n;
      rd_tok <= ~fl_n;
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
    end else begin
      wr_tok <= (wr_tok & ~wr_last) | xi.wr;
      rd_tok <= (rd_tok & ~rd_last) | xi.rd;
      if (wr_acc) wptr <= AW'(ptr_step(32'(wptr), DEPTH));
      if (rd_acc) rptr <= AW'(ptr_step(32'(rptr), DEPTH));
      case ({wr_acc, rd_acc})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4
  wr_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xo.wr |=> !xo.wr);
  // R5
  rd_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xo.rd |=> !xo.rd);
  // R4
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xo.wr && !xi.wr) |=> !wr_tok);
  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ff_n && !rd_acc) |=> !ff_n);
  // R9
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ef_n && !wr_acc) |=> !ef_n);
endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fl_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  xlink_t        xi,
  output xlink_t        xo,
  output logic [DW-1:0] rd_q,
  output logic          wr_tok,
  output logic          rd_tok,
  output logic          ff_n,
  output logic          ef_n
);
  logic          wr_acc, rd_acc;
  logic [AW-1:0] wptr, rptr;

  chain_slice_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fl_n(fl_n), .wr_en(wr_en), .rd_en(rd_en),
    .xi(xi), .xo(xo), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .wptr(wptr), .rptr(rptr), .wr_tok(wr_tok), .rd_tok(rd_tok),
    .ff_n(ff_n), .ef_n(ef_n)
  );

  chain_slice_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_acc), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(rd_q)
  );

  // R3
  read_needs_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> (rd_tok && ef_n));
endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int DW          = 9,
  parameter int SLICE_DEPTH = 4,
  parameter int N_SLICES    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  output logic [DW-1:0]       rd_data,
  output logic                full_n,
  output logic                empty_n,
  output logic [N_SLICES-1:0] wr_owner,
  output logic [N_SLICES-1:0] rd_owner
);
  xlink_t              xo_v [N_SLICES];
  logic [DW-1:0]       q_v  [N_SLICES];
  logic [N_SLICES-1:0] ff_v, ef_v;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    localparam int PREV = (k + N_SLICES - 1) % N_SLICES;
    localparam int NEXT = (k + 1) % N_SLICES;

    chain_slice #(.DW(DW), .DEPTH(SLICE_DEPTH)) u_slice (
      .clk(clk), .rst_n(rst_n), .fl_n((k == 0) ? 1'b0 : 1'b1),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .xi(xo_v[PREV]), .xo(xo_v[k]), .rd_q(q_v[k]),
      .wr_tok(wr_owner[k]), .rd_tok(rd_owner[k]),
      .ff_n(ff_v[k]), .ef_n(ef_v[k])
    );

    // R6
    wr_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xo_v[k].wr |=> wr_owner[NEXT]);
    // R6
    rd_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xo_v[k].rd |=> rd_owner[NEXT]);
  end

  assign full_n  = |ff_v;
  assign empty_n = |ef_v;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_SLICES; k++)
      if (rd_owner[k]) rd_data = q_v[k];
  end

  // R1
  wr_token_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_owner) == 1);
  // R1
  rd_token_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_owner) == 1);
  // R9
  ring_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !wr_en) |=> !empty_n);
endmodule

// File: tb/sim_fifo_chain.sv
`timescale 1ns/1ps
module sim_fifo_chain;
  localparam int DW = 9, D = 4, N = 3, CAP = N * D;

  logic          clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data0, rd_data1;
  logic          full0, empty0, full1, empty1;
  logic [N-1:0]  wown0, rown0;
  logic [0:0]    wown1, rown1;

  int tests = 0, fails = 0, wc0 = 0, rc0 = 0, dctr = 0;
  logic [DW-1:0] q0 [$];
  logic [DW-1:0] q1 [$];
  string phase = "R1";

  always #5 clk = ~clk;

  fifo_chain #(.DW(DW), .SLICE_DEPTH(D), .N_SLICES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data0), .full_n(full0), .empty_n(empty0),
    .wr_owner(wown0), .rd_owner(rown0));

  fifo_chain #(.DW(DW), .SLICE_DEPTH(D), .N_SLICES(1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data1), .full_n(full1), .empty_n(empty1),
    .wr_owner(wown1), .rd_owner(rown1));

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] ew, er;
    ew = N'(1 << ((wc0 / D) % N));
    er = N'(1 << ((rc0 / D) % N));
    check(empty0 == (q0.size() != 0), "R7 empty_n", empty0, q0.size() != 0);
    check(full0 == (q0.size() != CAP), "R7 full_n / R10 capacity", full0, q0.size() != CAP);
    if (q0.size() != 0) check(rd_data0 == q0[0], "R3 rd_data / R10 order", rd_data0, q0[0]);
    check(wown0 == ew, "R4 R6 wr_owner", wown0, ew);
    check(rown0 == er, "R5 R6 rd_owner", rown0, er);
    check(empty1 == (q1.size() != 0), "R11 empty_n", empty1, q1.size() != 0);
    check(full1 == (q1.size() != D), "R11 full_n", full1, q1.size() != D);
    if (q1.size() != 0) check(rd_data1 == q1[0], "R11 rd_data", rd_data1, q1[0]);
    check(wown1 == 1'b1 && rown1 == 1'b1, "R11 tokens", {wown1, rown1}, 2'b11);
  endtask

  task automatic step(input logic w, input logic r);
    logic wa0, ra0, wa1, ra1;
    @(negedge clk);
    compare_all();
    wr_en = w; rd_en = r;
    dctr++;
    wr_data = DW'(dctr * 37 + 5);
    @(posedge clk);
    wa0 = w && q0.size() < CAP; ra0 = r && q0.size() > 0;
    wa1 = w && q1.size() < D;   ra1 = r && q1.size() > 0;
    if (ra0) begin void'(q0.pop_front()); rc0++; end
    if (wa0) begin q0.push_back(wr_data); wc0++; end
    if (ra1) void'(q1.pop_front());
    if (wa1) q1.push_back(wr_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    check(wown0 == 3'b001 && rown0 == 3'b001, "R1 tokens at slice 0", {wown0, rown0}, 6'b001001);
    check(!empty0 && full0, "R1 flags", {empty0, full0}, 2'b01);
    phase = "R2 R4 R10"; for (int i = 0; i < CAP; i++) step(1, 0);
    phase = "R8";        for (int i = 0; i < 3; i++) step(1, 0);
    step(1, 1); step(1, 0);
    phase = "R3 R5 R6";  for (int i = 0; i < CAP + 2; i++) step(0, 1);
    phase = "R9";        for (int i = 0; i < 3; i++) step(0, 1);
    step(1, 1); step(0, 1); step(0, 1);
    phase = "R6 R10 mix70"; for (int i = 0; i < 300; i++) step(($urandom % 10) < 7, ($urandom % 10) < 3);
    phase = "R6 R10 mix50"; for (int i = 0; i < 300; i++) step(($urandom % 10) < 5, ($urandom % 10) < 5);
    phase = "R6 R10 mix30"; for (int i = 0; i < 300; i++) step(($urandom % 10) < 3, ($urandom % 10) < 7);
    step(0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule